// File: doc/BRIEF.md
# Multi-Ratio Deserializer with Lane Centring and Parity

This block turns a serial bit stream into parallel words. One bit is taken on each rising edge of the bit clock. A two-bit ratio select sets the word width to 4, 8, 10 or 16 bits. Every finished word is placed on a 16-lane output bus, inside a window of lanes centred on the middle of the bus. The lanes outside that window are driven to zero. With each word the block also gives an even-parity bit and a one-cycle strobe that tells the parallel side a new word is present.

An external aligner can send a restart pulse to move the word boundary. The restart drops any partly collected word, and the bit after the restart becomes the first bit of a new word. The ratio select is read only during reset and on a restart. Changing it at any other time has no effect on the word in progress. A design that holds the parallel side to 400 Mbit/s per lane gets a serial limit of 1.6 Gbit/s at the 4-bit width.

Top module: `multi_ratio_deser`

## Requirements
- R1: The ratio select sets the word width: 2'b00 gives 4 bits, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 16. The strobe comes on the last bit of each word, and on no earlier bit.
- R2: A word of width 4 uses lanes 6..9, width 8 uses lanes 4..11, width 10 uses lanes 3..12 and width 16 uses lanes 0..15. An all-ones word therefore reads 16'h03C0, 16'h0FF0, 16'h1FF8 or 16'hFFFF.
- R3: On every strobe, each lane outside the window of the active width reads 0.
- R4: The first bit received in a word appears on the lowest lane of the window. Each later bit goes to the next lane up.
- R5: `word_vld_o` is high for exactly one clock after the clock edge that takes in the last bit of a word. Word and parity are updated on that same edge.
- R6: Between strobes, `word_o` and `parity_o` hold the last word presented.
- R7: `parity_o` makes the count of ones in `word_o` plus `parity_o` even.
- R8: If `restart_i` is high on an edge, the bit on `bit_i` at that edge is dropped, the partial word is cleared and no strobe is produced. The next bit is the first bit of a word.
- R9: The block takes a new value of `ratio_sel_i` only during reset or on a restart. At any other time the width in use does not change.
- R10: After reset, `word_o`, `word_vld_o` and `parity_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| ratio_sel_i | input | 2 | Word width select |
| restart_i | input | 1 | Word boundary restart from the aligner |
| word_o | output | 16 | Parallel word on centred lanes |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| parity_o | output | 1 | Even parity of word_o |

## Verification
A wrong bit count changes the spacing between strobes. It can be seen at the ports within one word time, at most 16 cycles. A wrong window or lane order shows up in `word_o` on the first strobe after it. A wrong parity shows up on that same strobe.

A width that changes without a restart, or a restart that does not clear the count, moves the next strobe away from where the reference model expects it. The bench compares against the model on every clock, so the first stray or missing strobe is reported in the cycle it happens.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int LANES = 16;
    localparam int CNT_W = $clog2(LANES);

    typedef enum logic [1:0] {
        RATIO_4  = 2'b00,
        RATIO_8  = 2'b01,
        RATIO_10 = 2'b10,
        RATIO_16 = 2'b11
    } ratio_e;

    // Number of bits in one word for a given ratio.
    function automatic logic [CNT_W:0] ratio_width(ratio_e r);
        case (r)
            RATIO_4:  return (CNT_W+1)'(4);
            RATIO_8:  return (CNT_W+1)'(8);
            RATIO_10: return (CNT_W+1)'(10);
            default:  return (CNT_W+1)'(LANES);
        endcase
    endfunction

    // Lowest lane of the centred window.
    function automatic logic [CNT_W-1:0] ratio_base(ratio_e r);
        return CNT_W'((LANES - int'(ratio_width(r))) / 2);
    endfunction

    // Lanes that carry data at a given ratio.
    function automatic logic [LANES-1:0] lane_mask(ratio_e r);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (i >= int'(ratio_base(r))) &&
                   (i < int'(ratio_base(r)) + int'(ratio_width(r)));
        end
        return m;
    endfunction

endpackage

// File: rtl/deser_collector.sv
module deser_collector
    import deser_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_i,
    input  logic [1:0]       ratio_sel_i,
    input  logic             restart_i,
    output ratio_e           ratio_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o,
    output logic [LANES-1:0] raw_o
);

    typedef struct packed {
        ratio_e           ratio;
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] acc;
    } coll_t;

    coll_t st_d, st_q;
    logic  last_c;

    always_comb begin
        st_d   = st_q;
        last_c = (st_q.cnt == CNT_W'(ratio_width(st_q.ratio) - 1'b1));
        // Word so far, with the current bit placed at its index.
        raw_o            = st_q.acc;
        raw_o[st_q.cnt]  = bit_i;
        done_o           = last_c && !restart_i;

        if (restart_i) begin
            st_d.ratio = ratio_e'(ratio_sel_i);
            st_d.cnt   = '0;
            st_d.acc   = '0;
        end else if (last_c) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.acc = raw_o;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.ratio <= ratio_e'(ratio_sel_i);
            st_q.cnt   <= '0;
            st_q.acc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o = st_q.ratio;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/deser_lane_placer.sv
module deser_lane_placer
    import deser_pkg::*;
(
    input  ratio_e           ratio_i,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] placed_o
);

    logic [LANES-1:0] low_keep;

    // Keep only the bits that belong to the active width.
    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign low_keep[i] = raw_i[i] && (i < int'(ratio_width(ratio_i)));
    end

    assign placed_o = low_keep << ratio_base(ratio_i);

endmodule

// File: rtl/deser_parity.sv
module deser_parity #(
    parameter int N = 16
) (
    input  logic [N-1:0] data_i,
    output logic         par_o
);

    always_comb begin
        par_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            par_o = par_o ^ data_i[i];
        end
    end

endmodule

// File: rtl/multi_ratio_deser.sv
module multi_ratio_deser
    import deser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_i,
    input  logic [1:0]        ratio_sel_i,
    input  logic              restart_i,
    output logic [LANES-1:0]  word_o,
    output logic              word_vld_o,
    output logic              parity_o
);

    typedef struct packed {
        logic [LANES-1:0] word;
        logic             vld;
        logic             par;
    } out_t;

    ratio_e           act_ratio;
    logic [CNT_W-1:0] bit_cnt;
    logic             done;
    logic [LANES-1:0] raw_word;
    logic [LANES-1:0] placed_word;
    logic             placed_par;
    out_t             out_d, out_q;

    deser_collector u_collector (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bit_i       (bit_i),
        .ratio_sel_i (ratio_sel_i),
        .restart_i   (restart_i),
        .ratio_o     (act_ratio),
        .cnt_o       (bit_cnt),
        .done_o      (done),
        .raw_o       (raw_word)
    );

    deser_lane_placer u_placer (
        .ratio_i  (act_ratio),
        .raw_i    (raw_word),
        .placed_o (placed_word)
    );

    deser_parity #(.N(LANES)) u_parity (
        .data_i (placed_word),
        .par_o  (placed_par)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = done;
        if (done) begin
            out_d.word = placed_word;
            out_d.par  = placed_par;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o     = out_q.word;
    assign word_vld_o = out_q.vld;
    assign parity_o   = out_q.par;

endmodule

// File: rtl/deser_checker.sv
module deser_checker
    import deser_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             restart_i,
    input logic [LANES-1:0] word_o,
    input logic             word_vld_o,
    input logic             parity_o,
    input ratio_e           act_ratio,
    input logic [CNT_W-1:0] bit_cnt
);

    assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(bit_cnt) < int'(ratio_width(act_ratio)));

    assert_idle_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |-> ((word_o & ~lane_mask(act_ratio)) == '0));

    assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_vld_o |=> !word_vld_o);

    assert_hold_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_vld_o |-> ($stable(word_o) && $stable(parity_o)));

    assert_even_parity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((($countones(word_o) + int'(parity_o)) % 2) == 0));

    assert_restart_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (!word_vld_o && bit_cnt == '0));

    assert_ratio_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !restart_i |=> $stable(act_ratio));

endmodule

bind multi_ratio_deser deser_checker u_deser_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .parity_o   (parity_o),
    .act_ratio  (act_ratio),
    .bit_cnt    (bit_cnt)
);

// File: tb/test_multi_ratio_deser.sv
`timescale 1ns/1ps
module test_multi_ratio_deser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_i = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        restart = 1'b0;
    logic [15:0] word_o;
    logic        word_vld_o;
    logic        parity_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    multi_ratio_deser i_multi_ratio_deser (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bit_i       (bit_i),
        .ratio_sel_i (sel),
        .restart_i   (restart),
        .word_o      (word_o),
        .word_vld_o  (word_vld_o),
        .parity_o    (parity_o)
    );

    function automatic int width_of(logic [1:0] r);
        return (r == 2'd0) ? 4 : (r == 2'd1) ? 8 : (r == 2'd2) ? 10 : 16;
    endfunction

    function automatic logic [15:0] mask_of(logic [1:0] r);
        return (r == 2'd0) ? 16'h03C0 : (r == 2'd1) ? 16'h0FF0 :
               (r == 2'd2) ? 16'h1FF8 : 16'hFFFF;
    endfunction

    // Reference model
    int          m_width;
    bit          m_bits[$];
    logic [15:0] m_word = '0;
    logic        m_vld = 1'b0;
    logic        m_par = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_width = width_of(sel);
            m_bits.delete();
            m_word = '0; m_vld = 1'b0; m_par = 1'b0;
        end else begin
            m_vld = 1'b0;
            if (restart) begin
                m_bits.delete();
                m_width = width_of(sel);
            end else begin
                m_bits.push_back(bit_i);
                if (m_bits.size() == m_width) begin
                    int lo;
                    lo = (16 - m_width) / 2;
                    m_word = '0;
                    for (int k = 0; k < m_width; k++) m_word[lo + k] = m_bits[k];
                    m_par = ^m_word;
                    m_vld = 1'b1;
                    m_bits.delete();
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(word_vld_o == m_vld, "R5 strobe", 16'(word_vld_o), 16'(m_vld));
            chk(word_o == m_word, m_vld ? "R4 word" : "R6 held word", word_o, m_word);
            chk(parity_o == m_par, "R7 parity", 16'(parity_o), 16'(m_par));
        end
    end

    task automatic step(input logic b, input logic rs);
        bit_i = b; restart = rs;
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(word_o == 16'h0 && !word_vld_o && !parity_o, "R10 reset state",
            word_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_o == 16'h0 && !word_vld_o && !parity_o, "R10 after release",
            word_o, 16'h0);

        for (int r = 0; r < 4; r++) begin
            int w;
            int lo;
            w = width_of(2'(r));
            lo = (16 - w) / 2;
            sel = 2'(r);
            step(1'b0, 1'b1);
            for (int k = 0; k < w - 1; k++) begin
                step(1'b1, 1'b0);
                chk(!word_vld_o, "R1 early strobe", 16'(word_vld_o), 16'd0);
            end
            step(1'b1, 1'b0);
            chk(word_vld_o, "R1 strobe on last bit", 16'(word_vld_o), 16'd1);
            chk(word_o == mask_of(2'(r)), "R2 window", word_o, mask_of(2'(r)));
            chk((word_o & ~mask_of(2'(r))) == 16'h0, "R3 idle lanes",
                word_o & ~mask_of(2'(r)), 16'h0);
            step(1'b1, 1'b0);
            for (int k = 1; k < w; k++) step(1'b0, 1'b0);
            chk(word_o == (16'h1 << lo), "R4 first bit lowest lane", word_o, 16'h1 << lo);
            chk(parity_o == 1'b1, "R7 single one", 16'(parity_o), 16'd1);
            for (int k = 0; k < 3 * w; k++) step(1'($urandom_range(0, 1)), 1'b0);
        end

        // R8: restart drops a partial word
        sel = 2'b01;
        step(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk(!word_vld_o, "R8 no strobe on restart", 16'(word_vld_o), 16'd0);
        for (int k = 0; k < 7; k++) begin
            step(1'(k % 2), 1'b0);
            chk(!word_vld_o, "R8 partial discarded", 16'(word_vld_o), 16'd0);
        end
        step(1'b1, 1'b0);
        chk(word_vld_o, "R8 fresh word", 16'(word_vld_o), 16'd1);

        // R9: select change without restart has no effect
        sel = 2'b00;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        sel = 2'b11;
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk(word_vld_o, "R9 width kept at 4", 16'(word_vld_o), 16'd1);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
        chk(word_vld_o && word_o == 16'h03C0, "R9 second word 4 wide", word_o, 16'h03C0);
        step(1'b0, 1'b1);
        for (int k = 0; k < 15; k++) step(1'b1, 1'b0);
        chk(!word_vld_o, "R9 new width after restart", 16'(word_vld_o), 16'd0);
        step(1'b1, 1'b0);
        chk(word_vld_o && word_o == 16'hFFFF, "R9 sixteen wide", word_o, 16'hFFFF);
        step(1'b0, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule